// File: doc/BRIEF.md
# Page-Write EEPROM Device Sequencer

This block is a clocked model of the control logic in a byte-wide parallel EEPROM. It samples three active-low strobes (chip enable, write enable, output enable), a 17-bit address and an 8-bit data bus. Byte loads that hit the same page go into a page buffer. Each accepted load reopens a load window. When the window closes with no further load, the block enters a self-timed programming phase. At the end of that phase every loaded byte is written into an on-chip register-file array in one clock edge.

While programming is under way, a read returns a status byte in place of stored data. Bit 7 is the inverse of bit 7 of the last byte loaded. Bit 6 flips after each completed read access. The load window and the programming time are counted in clock cycles and set by parameters, so a testbench can shorten them. The array depth is also a parameter. Array index bits above the array depth are dropped.

Top module: `eeprom_page_seq`

## Requirements
- R1: After reset the data bus is not driven, and every array location reads 8'hFF.
- R2: A read is active when chip enable and output enable are both sampled low. The bus is then driven with the array byte at the sampled address. The bus is released whenever either of the two is high. Strobes are sampled on one clock edge, and the output follows in the same cycle.
- R3: A byte load takes place only while chip enable and write enable are low and output enable is high. The address is taken in the first sampled cycle in which this holds, whichever strobe fell last. The data is taken in the last sampled cycle in which it holds, whichever strobe rose first.
- R4: Loads whose address bits [16:8] equal those of the first load share one page buffer. All of them are committed to the array together, addressed by their bits [7:0].
- R5: A load whose address bits [16:8] differ from those of the page being loaded is dropped. It does not reopen the load window.
- R6: Each accepted load reopens the window. Programming starts only after LOAD_WIN cycles pass with no accepted load in progress.
- R7: Programming lasts PROG_CYC cycles. Until it ends, the array keeps its old contents. Reads before programming starts return the old bytes.
- R8: During programming, bit 7 of any read is the inverse of bit 7 of the last loaded byte, and bits [5:0] are that byte's bits [5:0]. After programming, reads return the true data.
- R9: During programming, bit 6 flips after every completed read access. Outside programming it holds, so repeated reads return the same value.
- R10: Write strobes that begin during programming are ignored and do not start a new page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | 17 | Byte address; bits [16:8] select the page |
| data_i | input | 8 | Write data from the host |
| data_o | output | 8 | Read data or status byte |
| data_oe_o | output | 1 | High while the block drives the data bus |

## Verification
The hardest states to reach are those that depend on the position in time of a strobe relative to the two internal counters. Examples are a load that arrives just inside the load window, a write that starts while programming is under way, and a pair of reads that must both fall inside the programming phase. The bench sets LOAD_WIN and PROG_CYC to small values and counts idle cycles from the strobe release it drives. This places loads a few cycles short of the window limit and places status reads and stray writes well inside the programming phase. Each case is then judged from the array contents that are read back after the commit.

// File: rtl/eps_pkg.sv
package eps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } seq_state_e;
endpackage

// File: rtl/eps_strobe_sync.sv
module eps_strobe_sync #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_start_o,
  output logic              wr_end_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_act_o,
  output logic              rd_end_o
);
  logic ce_q, we_q, oe_q, wr_q, rd_q;
  logic [ADDR_W-1:0] addr_q, wr_addr_q;
  logic [DATA_W-1:0] data_q, wr_data_q;
  logic wr_now, rd_now;

  assign wr_now = !ce_q && !we_q && oe_q;
  assign rd_now = !ce_q && !oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q      <= 1'b1;
      we_q      <= 1'b1;
      oe_q      <= 1'b1;
      addr_q    <= '0;
      data_q    <= '0;
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      ce_q   <= ce_ni;
      we_q   <= we_ni;
      oe_q   <= oe_ni;
      addr_q <= addr_i;
      data_q <= data_i;
      wr_q   <= wr_now;
      rd_q   <= rd_now;
      if (wr_now && !wr_q) wr_addr_q <= addr_q;  // last falling strobe
      if (wr_now)          wr_data_q <= data_q;  // held until first rising strobe
    end
  end

  assign addr_o     = addr_q;
  assign wr_start_o = wr_now && !wr_q;
  assign wr_end_o   = !wr_now && wr_q;
  assign wr_addr_o  = wr_addr_q;
  assign wr_data_o  = wr_data_q;
  assign rd_act_o   = rd_now;
  assign rd_end_o   = !rd_now && rd_q;
endmodule

// File: rtl/eps_page_buf.sv
module eps_page_buf #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 8,
  parameter int PG_W   = 9,
  localparam int PAGE_BYTES = 1 << PAGE_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              set_page_i,
  input  logic [PG_W-1:0]                   page_i,
  input  logic                              load_i,
  input  logic [PAGE_W-1:0]                 load_off_i,
  input  logic [DATA_W-1:0]                 load_data_i,
  input  logic                              clr_i,
  output logic                              have_page_o,
  output logic [PG_W-1:0]                   page_o,
  output logic [PAGE_BYTES-1:0]             valid_o,
  output logic [PAGE_BYTES-1:0][DATA_W-1:0] bytes_o
);
  logic            have_q;
  logic [PG_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      page_q <= '0;
    end else if (clr_i) begin
      have_q <= 1'b0;
    end else if (set_page_i) begin
      have_q <= 1'b1;
      page_q <= page_i;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[g] <= 1'b0;
        bytes_o[g] <= '0;
      end else if (clr_i) begin
        valid_o[g] <= 1'b0;
      end else if (load_i && load_off_i == PAGE_W'(g)) begin
        valid_o[g] <= 1'b1;
        bytes_o[g] <= load_data_i;
      end
    end
  end

  assign have_page_o = have_q;
  assign page_o      = page_q;

  // page address is frozen once the first load is accepted
  assert_page_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (have_q && !clr_i) |=> $stable(page_q));
endmodule

// File: rtl/eps_ctrl.sv
module eps_ctrl #(
  parameter int LOAD_WIN = 20000,
  parameter int PROG_CYC = 1000000,
  localparam int WIN_W  = $clog2(LOAD_WIN + 1),
  localparam int PROG_W = $clog2(PROG_CYC + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_start_i,
  input  logic                wr_end_i,
  input  logic                page_ok_i,
  input  logic                rd_end_i,
  output logic                accept_o,
  output logic                store_o,
  output logic                commit_o,
  output logic                busy_o,
  output logic                toggle_o
);
  import eps_pkg::*;

  seq_state_e  state_q;
  logic [WIN_W-1:0]  win_q;
  logic [PROG_W-1:0] prog_q;
  logic acc_q, tog_q;

  assign accept_o = wr_start_i && (state_q != ST_PROG) && page_ok_i;
  assign store_o  = wr_end_i && acc_q;
  assign commit_o = (state_q == ST_PROG) && (prog_q == PROG_W'(PROG_CYC - 1));
  assign busy_o   = (state_q == ST_PROG);
  assign toggle_o = tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      win_q   <= '0;
      prog_q  <= '0;
      acc_q   <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      if (accept_o)      acc_q <= 1'b1;
      else if (wr_end_i) acc_q <= 1'b0;

      if (rd_end_i && state_q == ST_PROG) tog_q <= !tog_q;

      unique case (state_q)
        ST_IDLE: begin
          if (accept_o) begin
            state_q <= ST_LOAD;
            win_q   <= '0;
          end
        end
        ST_LOAD: begin
          if (accept_o)   win_q <= '0;
          else if (acc_q) win_q <= '0;  // window runs from strobe release
          else if (win_q == WIN_W'(LOAD_WIN - 1)) begin
            state_q <= ST_PROG;
            prog_q  <= '0;
          end else win_q <= win_q + 1'b1;
        end
        ST_PROG: begin
          if (commit_o) state_q <= ST_IDLE;
          else          prog_q  <= prog_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_no_accept_prog_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROG) |-> !accept_o);

  assert_prog_from_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(state_q) == ST_LOAD && !$past(acc_q));

  assert_prog_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> prog_q < PROG_W'(PROG_CYC));

  assert_toggle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_PROG) |=> $stable(tog_q));
endmodule

// File: rtl/eeprom_page_seq.sv
module eeprom_page_seq #(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int PAGE_W   = 8,
  parameter int ARR_AW   = 10,
  parameter int LOAD_WIN = 20000,
  parameter int PROG_CYC = 1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int PG_W       = ADDR_W - PAGE_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int ARR_DEPTH  = 1 << ARR_AW;
  localparam int ARR_PG_W   = ARR_AW - PAGE_W;

  logic [ADDR_W-1:0] addr_q, wr_addr;
  logic [DATA_W-1:0] wr_data, last_q;
  logic wr_start, wr_end, rd_act, rd_end;
  logic accept, store, commit, busy, tog, page_ok, have_page;
  logic [PG_W-1:0] page;
  logic [PAGE_BYTES-1:0] valid;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] pbytes;
  logic [DATA_W-1:0] mem_q [ARR_DEPTH];

  eps_strobe_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sync (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni, .addr_i, .data_i,
    .addr_o(addr_q), .wr_start_o(wr_start), .wr_end_o(wr_end),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .rd_act_o(rd_act), .rd_end_o(rd_end)
  );

  assign page_ok = !have_page || (addr_q[ADDR_W-1:PAGE_W] == page);

  eps_ctrl #(.LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) u_ctrl (
    .clk_i, .rst_ni, .wr_start_i(wr_start), .wr_end_i(wr_end), .page_ok_i(page_ok),
    .rd_end_i(rd_end), .accept_o(accept), .store_o(store), .commit_o(commit),
    .busy_o(busy), .toggle_o(tog)
  );

  eps_page_buf #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .PG_W(PG_W)) u_pbuf (
    .clk_i, .rst_ni,
    .set_page_i(accept && !have_page), .page_i(addr_q[ADDR_W-1:PAGE_W]),
    .load_i(store), .load_off_i(wr_addr[PAGE_W-1:0]), .load_data_i(wr_data),
    .clr_i(commit), .have_page_o(have_page), .page_o(page),
    .valid_o(valid), .bytes_o(pbytes)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= '0;
    else if (store) last_q <= wr_data;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ARR_DEPTH; i++) mem_q[i] <= '1;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (valid[i]) mem_q[{page[ARR_PG_W-1:0], PAGE_W'(i)}] <= pbytes[i];
    end
  end

  always_comb begin
    data_o = '0;
    if (rd_act) begin
      if (busy) data_o = {!last_q[DATA_W-1], tog, last_q[DATA_W-3:0]};
      else      data_o = mem_q[addr_q[ARR_AW-1:0]];
    end
  end
  assign data_oe_o = rd_act;

  assert_commit_has_page_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> have_page);
endmodule

// File: tb/eeprom_page_seq_bench.sv
module eeprom_page_seq_bench;
  localparam int LW = 20;
  localparam int PC = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  data_o;
  logic        data_oe_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = !clk;

  eeprom_page_seq #(.LOAD_WIN(LW), .PROG_CYC(PC)) u_eeprom_page_seq (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(din), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  // {address, data}: one page, varied offsets; last entry has bit 7 clear
  localparam logic [24:0] TBL [6] = '{
    {17'h00200, 8'h5A}, {17'h00201, 8'hC3}, {17'h002FF, 8'h80},
    {17'h00210, 8'h01}, {17'h00280, 8'hEE}, {17'h00233, 8'h35}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [16:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); d = data_o; oe = data_oe_o;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wr(input logic [16:0] a0, input logic [16:0] a1,
                    input logic [7:0] d0, input logic [7:0] d1, input bit ce_late);
    @(negedge clk); addr = a0; din = d0; oe_n = 1'b1;
    if (ce_late) begin we_n = 1'b0; @(negedge clk); ce_n = 1'b0; end
    else begin ce_n = 1'b0; we_n = 1'b0; end
    @(negedge clk); addr = a1; din = d1;
    @(negedge clk); if (ce_late) ce_n = 1'b1; else we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic wr1(input logic [16:0] a, input logic [7:0] d);
    wr(a, a, d, d, 1'b0);
  endtask

  task automatic wait_commit();
    idle(LW + PC + 20);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    logic [7:0] d, d2;
    logic oe;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state
    chk("R1 bus idle", {7'b0, data_oe_o}, 8'h00);
    rd(17'h00000, d, oe);
    chk("R1 erased", d, 8'hFF);
    chk("R2 drive", {7'b0, oe}, 8'h01);

    // R2: bus released when either control is high
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
    @(negedge clk); chk("R2 oe high", {7'b0, data_oe_o}, 8'h00);
    ce_n = 1'b1; oe_n = 1'b0;
    @(negedge clk); chk("R2 ce high", {7'b0, data_oe_o}, 8'h00);
    oe_n = 1'b1;

    // R4/R7/R8/R9: table-driven page load
    foreach (TBL[i]) begin
      wr1(TBL[i][24:8], TBL[i][7:0]);
      idle(3);
    end
    rd(17'h00200, d, oe);
    chk("R7 old data before program", d, 8'hFF);
    idle(LW + 4);
    rd(17'h00233, d, oe);
    chk("R8 status bit7", d & 8'hBF, 8'hB5);
    idle(1);
    rd(17'h00005, d2, oe);
    chk("R9 toggle", {7'b0, d[6] ^ d2[6]}, 8'h01);
    chk("R8 status any addr", d2 & 8'hBF, 8'hB5);
    idle(PC + 10);
    foreach (TBL[i]) begin
      rd(TBL[i][24:8], d, oe);
      chk("R4 page commit", d, TBL[i][7:0]);
    end
    rd(17'h00233, d, oe); idle(1);
    rd(17'h00233, d2, oe);
    chk("R9 stopped", d2, d);
    chk("R8 true data", d2, 8'h35);

    // R5: foreign page load dropped
    wr1(17'h00100, 8'h11);
    idle(3);
    wr1(17'h00305, 8'h22);
    wait_commit();
    rd(17'h00100, d, oe);
    chk("R5 first page", d, 8'h11);
    rd(17'h00305, d, oe);
    chk("R5 foreign dropped", d, 8'hFF);

    // R10: write during programming ignored
    wr1(17'h00010, 8'h81);
    idle(LW + 6);
    wr1(17'h00020, 8'h44);
    wait_commit();
    rd(17'h00020, d, oe);
    chk("R10 ignored", d, 8'hFF);
    rd(17'h00010, d, oe);
    chk("R10 prior kept", d, 8'h81);

    // R3: address at start, data at end; WE- and CE-controlled
    wr(17'h00040, 17'h00041, 8'h12, 8'h34, 1'b0);
    idle(2);
    wr(17'h00050, 17'h00051, 8'h56, 8'h78, 1'b1);
    wait_commit();
    rd(17'h00040, d, oe);  chk("R3 we ctl", d, 8'h34);
    rd(17'h00041, d, oe);  chk("R3 late addr unused", d, 8'hFF);
    rd(17'h00050, d, oe);  chk("R3 ce ctl", d, 8'h78);

    // R3: output enable low blocks a write
    @(negedge clk); addr = 17'h00060; din = 8'h99; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    idle(2);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    wait_commit();
    rd(17'h00060, d, oe);  chk("R3 oe low no write", d, 8'hFF);

    // R6: loads just inside the window keep the page open
    wr1(17'h00070, 8'h0F);
    idle(LW - 6);
    wr1(17'h00071, 8'h1E);
    idle(LW - 6);
    rd(17'h00070, d, oe);
    chk("R6 window held open", d, 8'hFF);
    wait_commit();
    rd(17'h00070, d, oe);  chk("R6 byte a", d, 8'h0F);
    rd(17'h00071, d, oe);  chk("R6 byte b", d, 8'h1E);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      summary();
      $finish;
    end
  end
endmodule